// File: doc/BRIEF.md
# Two-Level Mapped Interrupt Controller

This block gathers a wide set of event inputs and folds them onto a few host interrupt lines. Each event has a sticky pending flag. A pending event that is also enabled is called active. Every event is steered to one channel, and many events may share the same channel. Every channel is steered to one host line. A host line rises when at least one active event reaches it and that host is enabled. Software can raise any event by a register write, and it clears pending flags with write-one-to-clear.

For each host, a read-only word reports the event that wins. The lowest-numbered channel that routes to the host and carries an active event is chosen first. Inside that channel, the lowest-numbered active event wins. No host number has a special role in the routing.

The configuration port is word addressed. Writes take effect on the clock edge. Reads are combinational and have no side effects. Address bits [10:8] select a region and bits [7:0] select an index within it.

Top module: `irqmux_top`

## Requirements
- R1: After reset all host lines are low, and all pending flags, event enables, host enables and map entries read as zero. Every winner word reads 0x8000_0000.
- R2: A rising edge on an event input sets its pending flag on that clock edge. An input held high does not set the flag again after it has been cleared. Pending word w (region 1, index w) holds events 32w to 32w+31, with bit i for event 32w+i.
- R3: Writing a one to bit i of region 2, index w sets pending flag 32w+i. Zero bits have no effect, and the region reads as zero.
- R4: Writing a one to bit i of region 1, index w clears pending flag 32w+i. If a rising edge or software set arrives for the same event in the same cycle, the set wins. No other action clears a pending flag.
- R5: Event enables sit in region 0, with the same word and bit layout as pending. A disabled event keeps its pending flag, but it drives no host line and is never a winner.
- R6: Region 3, index e holds the channel of event e in bits [3:0]. Several events may share a channel. A channel value of 10 or more routes the event nowhere.
- R7: Region 4, index c holds the host of channel c in bits [3:0]. A host value of 10 or more routes the channel nowhere.
- R8: Region 5, index 0, bit h enables host h. A disabled host holds its line low, but its winner word still reports.
- R9: A host line is a registered level. It changes one clock edge after the pending, enable or map state that causes the change.
- R10: Region 6, index h reads the winner for host h: the lowest routed channel that has an active event, then the lowest active event in that channel. The word is the event number, or 0x8000_0000 when there is no winner.
- R11: Routing treats every host number the same. Hosts 0, 1, 2 and 9 all follow the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | N_EV | Event input lines, edge detected |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 11 | Word address: region [10:8], index [7:0] |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| host_irq | output | N_HOST | Registered host interrupt levels |

## Verification
The first pattern puts several events on one channel. It separates event-order priority from channel-order priority. The second pattern moves those events to different channels that feed the same host. It shows whether the lower channel beats a lower event number. Out-of-range channel and host values, disabled events and disabled hosts are each applied while other events stay active. This exposes any gating that leaks or blocks too much. Held-high inputs, a clear that coincides with a rising edge, and hosts at both ends of the range test the edge detector, set-over-clear ordering and uniform routing.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
    localparam int ADDR_W = 11;

    typedef enum logic [2:0] {
        RG_EV_EN   = 3'd0,
        RG_PEND    = 3'd1,
        RG_SWSET   = 3'd2,
        RG_EV_MAP  = 3'd3,
        RG_CH_MAP  = 3'd4,
        RG_HOST_EN = 3'd5,
        RG_WINNER  = 3'd6,
        RG_RSVD    = 3'd7
    } region_e;

    localparam logic [31:0] NO_WINNER = 32'h8000_0000;
endpackage

// File: rtl/irqmux_event_bank.sv
module irqmux_event_bank #(
    parameter int N_EV = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] ev_in,
    input  logic [N_EV-1:0] set_vec,
    input  logic [N_EV-1:0] clr_vec,
    output logic [N_EV-1:0] rise,
    output logic [N_EV-1:0] pend
);
    logic [N_EV-1:0] ev_q;

    assign rise = ev_in & ~ev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
            pend <= '0;
        end else begin
            ev_q <= ev_in;
            pend <= (pend & ~clr_vec) | rise | set_vec;
        end
    end
endmodule

// File: rtl/irqmux_route.sv
module irqmux_route #(
    parameter int N_EV   = 64,
    parameter int N_CH   = 10,
    parameter int N_HOST = 10,
    parameter int CH_W   = 4,
    parameter int HOST_W = 4,
    parameter int EV_W   = 6
) (
    input  logic [N_EV-1:0]              active,
    input  logic [N_EV-1:0][CH_W-1:0]    ev_map,
    input  logic [N_CH-1:0][HOST_W-1:0]  ch_map,
    output logic [N_HOST-1:0]            host_hit,
    output logic [N_HOST-1:0][EV_W-1:0]  win_idx
);
    logic [N_CH-1:0]            ch_any;
    logic [N_CH-1:0][EV_W-1:0]  ch_first;

    // per channel: any active event, and the lowest such event
    always_comb begin
        ch_any   = '0;
        ch_first = '0;
        for (int c = 0; c < N_CH; c++) begin
            for (int e = N_EV - 1; e >= 0; e--) begin
                if (active[e] && ev_map[e] == CH_W'(c)) begin
                    ch_any[c]   = 1'b1;
                    ch_first[c] = EV_W'(e);
                end
            end
        end
    end

    // per host: lowest routed channel that carries an active event
    always_comb begin
        host_hit = '0;
        win_idx  = '0;
        for (int h = 0; h < N_HOST; h++) begin
            for (int c = N_CH - 1; c >= 0; c--) begin
                if (ch_any[c] && ch_map[c] == HOST_W'(h)) begin
                    host_hit[h] = 1'b1;
                    win_idx[h]  = ch_first[c];
                end
            end
        end
    end
endmodule

// File: rtl/irqmux_top.sv
module irqmux_top
    import irqmux_pkg::*;
#(
    parameter int N_EV   = 64,
    parameter int N_CH   = 10,
    parameter int N_HOST = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EV-1:0]   ev_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic [N_HOST-1:0] host_irq
);
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int HOST_W = (N_HOST > 1) ? $clog2(N_HOST) : 1;
    localparam int EV_W   = (N_EV > 1) ? $clog2(N_EV) : 1;

    region_e                      region;
    logic [7:0]                   idx;
    logic [N_EV-1:0]              ev_en;
    logic [N_EV-1:0]              set_vec;
    logic [N_EV-1:0]              clr_vec;
    logic [N_EV-1:0]              rise;
    logic [N_EV-1:0]              pend;
    logic [N_EV-1:0]              active;
    logic [N_EV-1:0][CH_W-1:0]    ev_map;
    logic [N_CH-1:0][HOST_W-1:0]  ch_map;
    logic [N_HOST-1:0]            host_en;
    logic [N_HOST-1:0]            host_hit;
    logic [N_HOST-1:0][EV_W-1:0]  win_idx;

    assign region = region_e'(cfg_addr[10:8]);
    assign idx    = cfg_addr[7:0];
    assign active = pend & ev_en;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int e = 0; e < N_EV; e++) begin
            if (cfg_we && idx == 8'(e / 32)) begin
                set_vec[e] = (region == RG_SWSET) && cfg_wdata[e % 32];
                clr_vec[e] = (region == RG_PEND) && cfg_wdata[e % 32];
            end
        end
    end

    irqmux_event_bank #(.N_EV(N_EV)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_in   (ev_in),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .rise    (rise),
        .pend    (pend)
    );

    irqmux_route #(
        .N_EV(N_EV), .N_CH(N_CH), .N_HOST(N_HOST),
        .CH_W(CH_W), .HOST_W(HOST_W), .EV_W(EV_W)
    ) route_i (
        .active   (active),
        .ev_map   (ev_map),
        .ch_map   (ch_map),
        .host_hit (host_hit),
        .win_idx  (win_idx)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_en   <= '0;
            ev_map  <= '0;
            ch_map  <= '0;
            host_en <= '0;
        end else if (cfg_we) begin
            for (int e = 0; e < N_EV; e++) begin
                if (region == RG_EV_EN && idx == 8'(e / 32))
                    ev_en[e] <= cfg_wdata[e % 32];
                if (region == RG_EV_MAP && idx == 8'(e))
                    ev_map[e] <= cfg_wdata[CH_W-1:0];
            end
            for (int c = 0; c < N_CH; c++) begin
                if (region == RG_CH_MAP && idx == 8'(c))
                    ch_map[c] <= cfg_wdata[HOST_W-1:0];
            end
            if (region == RG_HOST_EN && idx == 8'd0)
                host_en <= cfg_wdata[N_HOST-1:0];
        end
    end

    // registered host levels
    always_ff @(posedge clk) begin
        if (!rst_n) host_irq <= '0;
        else        host_irq <= host_en & host_hit;
    end

    // combinational read mux
    always_comb begin
        cfg_rdata = '0;
        unique case (region)
            RG_EV_EN, RG_PEND: begin
                for (int e = 0; e < N_EV; e++)
                    if (idx == 8'(e / 32))
                        cfg_rdata[e % 32] = (region == RG_PEND) ? pend[e] : ev_en[e];
            end
            RG_EV_MAP: begin
                for (int e = 0; e < N_EV; e++)
                    if (idx == 8'(e)) cfg_rdata[CH_W-1:0] = ev_map[e];
            end
            RG_CH_MAP: begin
                for (int c = 0; c < N_CH; c++)
                    if (idx == 8'(c)) cfg_rdata[HOST_W-1:0] = ch_map[c];
            end
            RG_HOST_EN: begin
                if (idx == 8'd0) cfg_rdata[N_HOST-1:0] = host_en;
            end
            RG_WINNER: begin
                for (int h = 0; h < N_HOST; h++)
                    if (idx == 8'(h))
                        cfg_rdata = host_hit[h] ? 32'(win_idx[h]) : NO_WINNER;
            end
            RG_SWSET, RG_RSVD: cfg_rdata = '0;
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqmux_chk.sv
module irqmux_chk #(
    parameter int N_EV   = 64,
    parameter int N_HOST = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [10:0]       cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic [N_EV-1:0]   rise,
    input logic [N_EV-1:0]   pend,
    input logic [N_EV-1:0]   active,
    input logic [N_HOST-1:0] host_en,
    input logic [N_HOST-1:0] host_irq
);
    AST_RISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise))); // R2

    AST_SWSET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr[10:8] == 3'd2 && cfg_addr[7:0] == 8'd0)
        |=> ((pend[31:0] & $past(cfg_wdata)) == $past(cfg_wdata))); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend) & ~pend)) |-> $past(cfg_we && cfg_addr[10:8] == 3'd1)); // R4

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (host_irq == '0)); // R5

    AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (|host_irq) |-> ((host_irq & ~$past(host_en)) == '0)); // R8
endmodule

bind irqmux_top irqmux_chk #(.N_EV(N_EV), .N_HOST(N_HOST)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .rise      (rise),
    .pend      (pend),
    .active    (active),
    .host_en   (host_en),
    .host_irq  (host_irq)
);

// File: tb/irqmux_top_tb_top.sv
`timescale 1ns/1ps
module irqmux_top_tb_top;
    localparam int NE = 64;
    localparam int NC = 10;
    localparam int NH = 10;
    localparam logic [31:0] NONE = 32'h8000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] ev_in = '0;
    logic          cfg_we = 1'b0;
    logic [10:0]   cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NH-1:0] host_irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    irqmux_top #(.N_EV(NE), .N_CH(NC), .N_HOST(NH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .host_irq(host_irq)
    );

    // behavioural reference model
    bit            m_pend [NE];
    bit            m_evq  [NE];
    bit            m_en   [NE];
    int            m_evmap[NE];
    int            m_chmap[NC];
    bit            m_hen  [NH];
    bit [NH-1:0]   m_irq;

    function automatic logic [31:0] m_winner(int h);
        for (int c = 0; c < NC; c++)
            if (m_chmap[c] == h)
                for (int e = 0; e < NE; e++)
                    if (m_pend[e] && m_en[e] && m_evmap[e] == c) return 32'(e);
        return NONE;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin
                m_pend[e] = 0; m_evq[e] = 0; m_en[e] = 0; m_evmap[e] = 0;
            end
            for (int c = 0; c < NC; c++) m_chmap[c] = 0;
            for (int h = 0; h < NH; h++) m_hen[h] = 0;
            m_irq = '0;
        end else begin
            int rg, ix;
            for (int h = 0; h < NH; h++)
                m_irq[h] = m_hen[h] && (m_winner(h) != NONE);
            rg = int'(cfg_addr[10:8]);
            ix = int'(cfg_addr[7:0]);
            for (int e = 0; e < NE; e++) begin
                bit hit, r, s, c;
                hit = cfg_we && ix == e / 32 && cfg_wdata[e % 32];
                r = ev_in[e] && !m_evq[e];
                s = hit && rg == 2;
                c = hit && rg == 1;
                m_pend[e] = (m_pend[e] && !c) || r || s;
                m_evq[e] = ev_in[e];
                if (cfg_we && rg == 0 && ix == e / 32) m_en[e] = cfg_wdata[e % 32];
            end
            if (cfg_we && rg == 3 && ix < NE) m_evmap[ix] = int'(cfg_wdata[3:0]);
            if (cfg_we && rg == 4 && ix < NC) m_chmap[ix] = int'(cfg_wdata[3:0]);
            if (cfg_we && rg == 5 && ix == 0)
                for (int h = 0; h < NH; h++) m_hen[h] = cfg_wdata[h];
        end
    end

    // every-clock comparison of host lines (R9, R11)
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (host_irq !== m_irq) begin
                n_fail++;
                $display("FAIL R9 host_irq actual=%h expected=%h at %0t", host_irq, m_irq, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] rg, input logic [7:0] ix, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {rg, ix}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [2:0] rg, input logic [7:0] ix,
                      input logic [31:0] exp);
        cfg_addr = {rg, ix};
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic win(input string tag, input int h);
        rd(tag, 3'd6, 8'(h), m_winner(h));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 host_irq", 32'(host_irq), 32'h0);
        rd("R1 pend0", 3'd1, 8'd0, 32'h0);
        rd("R1 pend1", 3'd1, 8'd1, 32'h0);
        rd("R1 en0", 3'd0, 8'd0, 32'h0);
        rd("R1 evmap5", 3'd3, 8'd5, 32'h0);
        rd("R1 chmap3", 3'd4, 8'd3, 32'h0);
        rd("R1 hosten", 3'd5, 8'd0, 32'h0);
        rd("R1 winner0", 3'd6, 8'd0, NONE);
        rd("R1 winner9", 3'd6, 8'd9, NONE);

        wr(3'd0, 8'd0, 32'hFFFF_FFFF);
        wr(3'd0, 8'd1, 32'hFFFF_FFFF);
        wr(3'd5, 8'd0, 32'h3FF);
        rd("R3 swset reads zero", 3'd2, 8'd0, 32'h0);

        // R2 rising edge on event 7
        ev_in[7] = 1'b1;
        @(negedge clk);
        rd("R2 pend after rise", 3'd1, 8'd0, 32'h80);
        rd("R10 winner0 ev7", 3'd6, 8'd0, 32'd7);
        chk("R9 not yet asserted", 32'(host_irq), 32'h0);
        @(negedge clk);
        chk("R9 asserted next edge", 32'(host_irq), 32'h1);
        // R4 clear while input held high; R2 no re-set from level
        wr(3'd1, 8'd0, 32'h80);
        repeat (2) @(negedge clk);
        rd("R2 held level no re-set", 3'd1, 8'd0, 32'h0);
        chk("R4 host low after clear", 32'(host_irq), 32'h0);
        ev_in[7] = 1'b0;

        // R2 high event via input
        ev_in[63] = 1'b1;
        @(negedge clk);
        rd("R2 pend1 ev63", 3'd1, 8'd1, 32'h8000_0000);
        rd("R10 winner0 ev63", 3'd6, 8'd0, 32'd63);
        ev_in[63] = 1'b0;
        wr(3'd1, 8'd1, 32'h8000_0000);

        // R3 software set
        wr(3'd2, 8'd1, 32'h100);
        rd("R3 pend1 ev40", 3'd1, 8'd1, 32'h100);
        rd("R10 winner0 ev40", 3'd6, 8'd0, 32'd40);
        wr(3'd2, 8'd0, 32'h8);
        rd("R10 lower event wins", 3'd6, 8'd0, 32'd3);

        // R6/R10 channel priority over event priority
        wr(3'd3, 8'd3, 32'd5);
        wr(3'd3, 8'd40, 32'd2);
        wr(3'd4, 8'd5, 32'd9);
        wr(3'd4, 8'd2, 32'd9);
        rd("R6 evmap readback", 3'd3, 8'd40, 32'd2);
        rd("R10 lower channel wins", 3'd6, 8'd9, 32'd40);
        rd("R10 host0 none", 3'd6, 8'd0, NONE);
        @(negedge clk);
        chk("R11 host9 line", 32'(host_irq), 32'h200);

        // R7 out-of-range host
        wr(3'd4, 8'd2, 32'd12);
        rd("R7 out-of-range host", 3'd6, 8'd9, 32'd3);
        // R6 out-of-range channel
        wr(3'd3, 8'd3, 32'd13);
        rd("R6 out-of-range channel", 3'd6, 8'd9, NONE);
        @(negedge clk);
        chk("R6 host9 low", 32'(host_irq), 32'h0);
        wr(3'd3, 8'd3, 32'd5);
        wr(3'd4, 8'd2, 32'd9);
        win("R10 model winner9", 9);

        // R5 event enables
        wr(3'd0, 8'd0, 32'h0);
        rd("R5 ev3 disabled", 3'd6, 8'd9, 32'd40);
        wr(3'd0, 8'd1, 32'h0);
        rd("R5 all disabled", 3'd6, 8'd9, NONE);
        rd("R5 pend0 kept", 3'd1, 8'd0, 32'h8);
        rd("R5 pend1 kept", 3'd1, 8'd1, 32'h100);
        @(negedge clk);
        chk("R5 host low", 32'(host_irq), 32'h0);
        wr(3'd0, 8'd0, 32'hFFFF_FFFF);
        wr(3'd0, 8'd1, 32'hFFFF_FFFF);

        // R8 host enable
        wr(3'd5, 8'd0, 32'h1FF);
        @(negedge clk);
        chk("R8 host9 gated", 32'(host_irq), 32'h0);
        rd("R8 winner still reported", 3'd6, 8'd9, 32'd40);
        wr(3'd5, 8'd0, 32'h3FF);
        @(negedge clk);
        chk("R8 host9 restored", 32'(host_irq), 32'h200);

        // R4 set beats simultaneous clear
        @(negedge clk);
        ev_in[3] = 1'b1;
        cfg_we = 1'b1; cfg_addr = {3'd1, 8'd0}; cfg_wdata = 32'h8;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
        rd("R4 set wins over clear", 3'd1, 8'd0, 32'h8);
        wr(3'd1, 8'd0, 32'h8);
        rd("R4 clear applied", 3'd1, 8'd0, 32'h0);
        ev_in[3] = 1'b0;

        // R11 hosts 1 and 2 route alike
        wr(3'd1, 8'd1, 32'hFFFF_FFFF);
        wr(3'd3, 8'd10, 32'd7);
        wr(3'd4, 8'd7, 32'd1);
        wr(3'd2, 8'd0, 32'h400);
        rd("R11 winner1", 3'd6, 8'd1, 32'd10);
        @(negedge clk);
        chk("R11 host1 line", 32'(host_irq), 32'h002);
        wr(3'd4, 8'd7, 32'd2);
        rd("R11 winner2", 3'd6, 8'd2, 32'd10);
        rd("R11 winner1 none", 3'd6, 8'd1, NONE);
        @(negedge clk);
        chk("R11 host2 line", 32'(host_irq), 32'h004);

        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule